// File: doc/BRIEF.md
# Keyboard Matrix and Peripheral Status Port

This block is the parallel-port glue for a small computer. The CPU writes an output byte that picks one keyboard row, chooses a floppy drive, selects the serial connector and drives the printer strobe. It reads back two bytes. The first gives the column state of the chosen keyboard row. The second collects printer busy, motor feedback, carrier detect and the write-protect state of the drive that is currently selected. A second output byte, also written by the CPU, carries a three-bit memory bank code.

The keyboard is a 10-row by 8-column switch matrix, supplied as one flat vector with row r in bits [8r+7:8r]. A key that is pressed reads 0. Writes take effect on the clock edge at which the write strobe is high. The read ports are combinational from the registered state and the live inputs.

Top module: `kbd_status_port`

## Requirements
- R1: While `wr_a` is high at a rising clock edge, `wdata_a` is stored, and from then on `row_sel` equals `wdata_a[3:0]`, `rs232_sel` equals `wdata_a[6]` and `prn_strobe` equals `wdata_a[7]`.
- R2: `rd_b` equals byte r of `key_matrix` (bits [8r+7:8r]), where r is the stored row number, for any row number from 0 to 9. A pressed key reads as 0.
- R3: When the stored row number is 10 to 15, `rd_b` reads 0xFF no matter what `key_matrix` holds.
- R4: A port A write with bit 4 set selects drive 0. A write with bit 5 set (and bit 4 clear) selects drive 1. A write with both bits set selects drive 1, because the bit 5 test is applied last. A write with neither bit set keeps the previous drive. `drive_sel` reports the drive (0 or 1).
- R5: `rd_c[7]` equals `wprot[drive_sel]`, the write-protect input of the selected drive.
- R6: `rd_c[4]` equals `prn_busy`, and `rd_c[5]` equals the inverse of `motor_on`.
- R7: `rd_c[6]` equals `carrier` when the parameter `HAS_CARRIER` is 1, and 0 otherwise. `rd_c[3:0]` always read 0.
- R8: While `wr_c` is high at a rising clock edge, `bank_sel` takes `wdata_c[2:0]`. Bit 3 and bits 7:4 of `wdata_c` have no effect on any output.
- R9: Reset (`rst_n` low, asynchronous) leaves the row number at 0, `drive_sel` at 0, `prn_strobe` at 1, `rs232_sel` at 0 and `bank_sel` at the parameter `BANK_RESET` (default 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_a | input | 1 | Write strobe for output port A |
| wdata_a | input | 8 | Port A data: row [3:0], drive 0 [4], drive 1 [5], serial select [6], strobe [7] |
| wr_c | input | 1 | Write strobe for output port C |
| wdata_c | input | 8 | Port C data: bank code [2:0] |
| key_matrix | input | 80 | Switch matrix, row r in bits [8r+7:8r], active low |
| prn_busy | input | 1 | Printer busy |
| motor_on | input | 1 | Floppy motor-on |
| carrier | input | 1 | Serial carrier detect |
| wprot | input | 2 | Write protect, one bit per drive |
| row_sel | output | 4 | Stored keyboard row number |
| drive_sel | output | 1 | Selected drive number |
| rs232_sel | output | 1 | Serial connector select |
| prn_strobe | output | 1 | Printer strobe |
| bank_sel | output | 3 | Memory bank code |
| rd_b | output | 8 | Column state of the selected row |
| rd_c | output | 8 | Status byte |

## Verification
The bench walks every row from 0 to 9 using patterns that differ per row, so a design that swapped rows or bytes would return the wrong byte. It then selects rows 10, 12 and 15 while every key is held down. A decoder that wrapped or truncated the row number would return live key data there instead of 0xFF. For drive selection, the bench checks a write with neither bit set, which must keep the last drive, and a write with both bits set, which must pick drive 1. It then confirms that write-protect follows the selected drive. A design that forgot the drive, or let bit 4 win, would report the wrong drive and the wrong protect bit. Finally, motor feedback polarity, the zero bits of the status byte, the ignored high bits of port C, and the reset values of the strobe and bank code are each checked directly.

// File: rtl/kbd_status_pkg.sv
package kbd_status_pkg;
   localparam int unsigned KBD_ROWS  = 10;
   localparam int unsigned KBD_COLS  = 8;
   localparam int unsigned ROW_BITS  = 4;
   localparam int unsigned BANK_BITS = 3;

   typedef struct packed {
      logic                 strobe;
      logic                 rs232;
      logic                 drive;
      logic [ROW_BITS-1:0]  row;
   } porta_state_t;

   localparam int unsigned BIT_DS0    = 4;
   localparam int unsigned BIT_DS1    = 5;
   localparam int unsigned BIT_RS232  = 6;
   localparam int unsigned BIT_STROBE = 7;

   localparam int unsigned STAT_BUSY  = 4;
   localparam int unsigned STAT_MFB   = 5;
   localparam int unsigned STAT_CD    = 6;
   localparam int unsigned STAT_WP    = 7;
endpackage

// File: rtl/kbd_porta_reg.sv
module kbd_porta_reg
   import kbd_status_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [DATA_W-1:0]  wdata,
   output porta_state_t       state
);
   initial begin
      assert (DATA_W >= BIT_STROBE + 1)
         else $error("kbd_porta_reg: DATA_W too small");
   end

   logic drive_next;

   always_comb begin
      drive_next = state.drive;
      if (wdata[BIT_DS0]) drive_next = 1'b0;
      if (wdata[BIT_DS1]) drive_next = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state.row    <= '0;
         state.drive  <= 1'b0;
         state.rs232  <= 1'b0;
         state.strobe <= 1'b1;
      end else if (wr) begin
         state.row    <= wdata[ROW_BITS-1:0];
         state.drive  <= drive_next;
         state.rs232  <= wdata[BIT_RS232];
         state.strobe <= wdata[BIT_STROBE];
      end
   end
endmodule

// File: rtl/kbd_row_mux.sv
module kbd_row_mux #(
   parameter int unsigned ROWS     = 10,
   parameter int unsigned COLS     = 8,
   parameter int unsigned SEL_W    = 4,
   parameter bit          REG_IDLE = 1'b1
) (
   input  logic [ROWS*COLS-1:0] matrix,
   input  logic [SEL_W-1:0]     sel,
   output logic [COLS-1:0]      cols
);
   localparam int unsigned CODES = 1 << SEL_W;

   initial begin
      assert (ROWS <= CODES) else $error("kbd_row_mux: select too narrow");
      assert (ROWS >= 1)     else $error("kbd_row_mux: no rows");
   end

   logic [COLS-1:0] row_arr [CODES];

   for (genvar g = 0; g < CODES; g++) begin : g_row
      if (g < ROWS) begin : g_real
         assign row_arr[g] = matrix[g*COLS +: COLS];
      end else begin : g_idle
         assign row_arr[g] = REG_IDLE ? '1 : '0;
      end
   end

   assign cols = row_arr[sel];
endmodule

// File: rtl/kbd_status_mux.sv
module kbd_status_mux
   import kbd_status_pkg::*;
#(
   parameter bit HAS_CARRIER = 1'b1
) (
   input  logic       prn_busy,
   input  logic       motor_on,
   input  logic       carrier,
   input  logic [1:0] wprot,
   input  logic       drive,
   output logic [7:0] status
);
   logic cd_bit;

   if (HAS_CARRIER) begin : g_cd
      assign cd_bit = carrier;
   end else begin : g_no_cd
      logic unused_cd;
      assign unused_cd = carrier;
      assign cd_bit    = 1'b0;
   end

   always_comb begin
      status             = '0;
      status[STAT_BUSY]  = prn_busy;
      status[STAT_MFB]   = ~motor_on;
      status[STAT_CD]    = cd_bit;
      status[STAT_WP]    = wprot[drive];
   end
endmodule

// File: rtl/kbd_status_port.sv
module kbd_status_port
   import kbd_status_pkg::*;
#(
   parameter int unsigned ROWS        = KBD_ROWS,
   parameter int unsigned COLS        = KBD_COLS,
   parameter bit          HAS_CARRIER = 1'b1,
   parameter logic [2:0]  BANK_RESET  = 3'd7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_a,
   input  logic [7:0]           wdata_a,
   input  logic                 wr_c,
   input  logic [7:0]           wdata_c,
   input  logic [ROWS*COLS-1:0] key_matrix,
   input  logic                 prn_busy,
   input  logic                 motor_on,
   input  logic                 carrier,
   input  logic [1:0]           wprot,
   output logic [3:0]           row_sel,
   output logic                 drive_sel,
   output logic                 rs232_sel,
   output logic                 prn_strobe,
   output logic [2:0]           bank_sel,
   output logic [COLS-1:0]      rd_b,
   output logic [7:0]           rd_c
);
   initial begin
      assert (COLS == 8) else $error("kbd_status_port: port B is 8 bits");
   end

   porta_state_t pa;
   logic [BANK_BITS-1:0] bank_q;
   logic [4:0] unused_c;

   assign unused_c = wdata_c[7:3];

   kbd_porta_reg #(.DATA_W(8)) u_pa (
      .clk(clk), .rst_n(rst_n), .wr(wr_a), .wdata(wdata_a), .state(pa)
   );

   kbd_row_mux #(.ROWS(ROWS), .COLS(COLS), .SEL_W(ROW_BITS), .REG_IDLE(1'b1)) u_mux (
      .matrix(key_matrix), .sel(pa.row), .cols(rd_b)
   );

   kbd_status_mux #(.HAS_CARRIER(HAS_CARRIER)) u_stat (
      .prn_busy(prn_busy), .motor_on(motor_on), .carrier(carrier),
      .wprot(wprot), .drive(pa.drive), .status(rd_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bank_q <= BANK_RESET;
      else if (wr_c) bank_q <= wdata_c[BANK_BITS-1:0];
   end

   assign row_sel    = pa.row;
   assign drive_sel  = pa.drive;
   assign rs232_sel  = pa.rs232;
   assign prn_strobe = pa.strobe;
   assign bank_sel   = bank_q;
endmodule

// File: rtl/kbd_status_port_chk.sv
module kbd_status_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_a,
   input logic [7:0]  wdata_a,
   input logic        wr_c,
   input logic [7:0]  wdata_c,
   input logic [79:0] key_matrix,
   input logic        motor_on,
   input logic [1:0]  wprot,
   input logic [3:0]  row_sel,
   input logic        drive_sel,
   input logic        prn_strobe,
   input logic [2:0]  bank_sel,
   input logic [7:0]  rd_b,
   input logic [7:0]  rd_c
);
   p_row_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a |=> (row_sel == $past(wdata_a[3:0]) && prn_strobe == $past(wdata_a[7])));

   p_idle_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (row_sel > 4'd9) |-> (rd_b == 8'hFF));

   p_row_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (row_sel <= 4'd9) |-> (rd_b == key_matrix[row_sel*8 +: 8]));

   p_drive_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_a || wdata_a[5:4] == 2'b00) |=> $stable(drive_sel));

   p_drive_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && wdata_a[5]) |=> drive_sel);

   p_wprot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_c[7] == wprot[drive_sel]);

   p_motor_fb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_c[5] != motor_on);

   p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_c[3:0] == 4'h0);

   p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_c |=> $stable(bank_sel));

   p_bank_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c |=> bank_sel == $past(wdata_c[2:0]));
endmodule

bind kbd_status_port kbd_status_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wdata_a(wdata_a),
   .wr_c(wr_c), .wdata_c(wdata_c), .key_matrix(key_matrix),
   .motor_on(motor_on), .wprot(wprot), .row_sel(row_sel),
   .drive_sel(drive_sel), .prn_strobe(prn_strobe), .bank_sel(bank_sel),
   .rd_b(rd_b), .rd_c(rd_c)
);

// File: tb/sim_kbd_status_port.sv
`timescale 1ns/1ps
module sim_kbd_status_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_a = 1'b0, wr_c = 1'b0;
   logic [7:0]  wdata_a = '0, wdata_c = '0;
   logic [79:0] key_matrix = '1;
   logic        prn_busy = 1'b0, motor_on = 1'b0, carrier = 1'b0;
   logic [1:0]  wprot = 2'b00;
   logic [3:0]  row_sel;
   logic        drive_sel, rs232_sel, prn_strobe;
   logic [2:0]  bank_sel;
   logic [7:0]  rd_b, rd_c;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   kbd_status_port u0 (
      .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wdata_a(wdata_a),
      .wr_c(wr_c), .wdata_c(wdata_c), .key_matrix(key_matrix),
      .prn_busy(prn_busy), .motor_on(motor_on), .carrier(carrier),
      .wprot(wprot), .row_sel(row_sel), .drive_sel(drive_sel),
      .rs232_sel(rs232_sel), .prn_strobe(prn_strobe), .bank_sel(bank_sel),
      .rd_b(rd_b), .rd_c(rd_c)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_a(input logic [7:0] d);
      @(negedge clk); wr_a = 1'b1; wdata_a = d;
      @(negedge clk); wr_a = 1'b0; wdata_a = 8'h00;
   endtask

   task automatic write_c(input logic [7:0] d);
      @(negedge clk); wr_c = 1'b1; wdata_c = d;
      @(negedge clk); wr_c = 1'b0; wdata_c = 8'h00;
   endtask

   task automatic t_reset_r9();
      check("R9 row", 32'(row_sel), 0);
      check("R9 drive", 32'(drive_sel), 0);
      check("R9 strobe", 32'(prn_strobe), 1);
      check("R9 rs232", 32'(rs232_sel), 0);
      check("R9 bank", 32'(bank_sel), 7);
   endtask

   task automatic t_porta_r1();
      write_a(8'hC3);
      check("R1 row", 32'(row_sel), 3);
      check("R1 rs232", 32'(rs232_sel), 1);
      check("R1 strobe", 32'(prn_strobe), 1);
      write_a(8'h05);
      check("R1 row2", 32'(row_sel), 5);
      check("R1 rs232 off", 32'(rs232_sel), 0);
      check("R1 strobe low", 32'(prn_strobe), 0);
   endtask

   task automatic t_rows_r2();
      for (int r = 0; r < 10; r++) key_matrix[r*8 +: 8] = 8'(8'hA0 ^ (r * 8'h13));
      for (int r = 0; r < 10; r++) begin
         write_a(8'(r));
         check("R2 row data", 32'(rd_b), 32'(8'(8'hA0 ^ (r * 8'h13))));
      end
   endtask

   task automatic t_idle_r3();
      key_matrix = '0;
      write_a(8'h0A); check("R3 row 10", 32'(rd_b), 32'hFF);
      write_a(8'h0C); check("R3 row 12", 32'(rd_b), 32'hFF);
      write_a(8'h0F); check("R3 row 15", 32'(rd_b), 32'hFF);
      write_a(8'h09); check("R2 row 9 all pressed", 32'(rd_b), 32'h00);
      key_matrix = '1;
   endtask

   task automatic t_drive_r4_r5();
      wprot = 2'b10;
      write_a(8'h20); check("R4 drive1", 32'(drive_sel), 1);
      #1 check("R5 wp drive1", 32'(rd_c[7]), 1);
      write_a(8'h00); check("R4 hold", 32'(drive_sel), 1);
      write_a(8'h10); check("R4 drive0", 32'(drive_sel), 0);
      check("R5 wp drive0", 32'(rd_c[7]), 0);
      write_a(8'h30); check("R4 both bits", 32'(drive_sel), 1);
      wprot = 2'b01; #1 check("R5 wp live", 32'(rd_c[7]), 0);
   endtask

   task automatic t_status_r6_r7();
      prn_busy = 1'b1; motor_on = 1'b0; carrier = 1'b1; #1;
      check("R6 busy", 32'(rd_c[4]), 1);
      check("R6 motor fb off", 32'(rd_c[5]), 1);
      check("R7 carrier", 32'(rd_c[6]), 1);
      check("R7 low zero", 32'(rd_c[3:0]), 0);
      prn_busy = 1'b0; motor_on = 1'b1; carrier = 1'b0; #1;
      check("R6 busy low", 32'(rd_c[4]), 0);
      check("R6 motor fb on", 32'(rd_c[5]), 0);
      check("R7 carrier low", 32'(rd_c[6]), 0);
   endtask

   task automatic t_bank_r8();
      write_c(8'h02); check("R8 bank", 32'(bank_sel), 2);
      write_c(8'hF8); check("R8 high bits ignored", 32'(bank_sel), 0);
      write_c(8'h0D); check("R8 bit3 ignored", 32'(bank_sel), 5);
      check("R8 port A untouched", 32'(drive_sel), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_r9();
      rst_n = 1'b1;
      @(negedge clk);
      t_porta_r1();
      t_rows_r2();
      t_idle_r3();
      t_drive_r4_r5();
      t_status_r6_r7();
      t_bank_r8();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule